// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Engine

This block is a bus-master engine that streams audio words between system memory and a codec link. Software builds a table of 8-byte descriptors in memory, each giving a buffer address, a byte count and three control flags. It writes the table location into the engine and sets the run bit. The engine then walks the table on its own. It fetches each descriptor over a simple memory port and moves one 32-bit word per codec request. It raises an interrupt when a descriptor marks the end of a page or the end of the table.

A jump flag lets a descriptor point back to an earlier entry, so a two-buffer ring can run forever. Software refills one buffer while the engine plays or captures the other. Software acknowledges each page by reading the status register. If an end of page arrives while the previous one is still unacknowledged, the engine does not stop. It flags a bus error and pauses. A paused engine is then shut down by clearing the run bit.

Top module: `adma_engine`

## Requirements
- R1: Writing the command register (register index 0) with bit 0 set while the engine is idle starts it. The engine fetches the descriptor at the table address. Command read-back bit 0 is 1 whenever the engine is active or paused.
- R2: A descriptor is two little-endian memory words. The word at the table address holds the buffer address. The word at table address + 4 holds the byte count in bits 15:0, end-of-table in bit 31, end-of-page in bit 30 and jump in bit 29. After a fetch without jump, the table address (register index 2) has advanced by 8.
- R3: Data moves as one 32-bit word per codec request, in descriptor order, and the buffer address advances by 4 per word. Command bit 3 at 0 reads memory and hands the word to the codec. Command bit 3 at 1 writes the word from the codec into memory.
- R4: When a descriptor with end-of-page completes, status bit 0 is set, the interrupt rises and the engine goes on to the next descriptor.
- R5: When a descriptor with end-of-page completes while status bit 0 is still set, status bit 1 (bus error) is set and the engine pauses.
- R6: Reading the status register (register index 1) returns bits 2:0 and clears all of them. The interrupt falls once no status bit remains.
- R7: A descriptor with jump set moves no data. Its address word becomes the new table address and the next fetch comes from there.
- R8: When a descriptor with end-of-table completes, status bit 2 is set, the interrupt rises and the engine returns to idle.
- R9: Writing the command register with bit 0 clear has no effect while the engine is running. While paused, it returns the engine to idle.
- R10: A memory access that ends with an error response sets status bit 1 and pauses the engine without passing a word to the codec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when index 1) |
| reg_addr | input | 2 | Register index: 0 command, 1 status, 2 table address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid during the read strobe |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_err | input | 1 | Error response, valid with acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| link_req | input | 1 | Codec requests one word |
| link_din | input | 32 | Word from the codec (capture) |
| link_ack | output | 1 | One-cycle pulse: a word has been served |
| link_dout | output | 32 | Word to the codec (playback), valid with link_ack |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that memory returns at most one acknowledge per request, that byte counts are multiples of four, and that status is never read in the same cycle that an end-of-page, error or end-of-table event occurs. The bench's memory model answers one cycle after it sees a request. Status reads happen only while the engine is stalled, paused or idle. All descriptor counts are multiples of four. The codec model holds its request level and moves to its next word only on the acknowledge pulse, which meets the handshake the hold and pulse properties expect.

// File: rtl/adma_pkg.sv
package adma_pkg;
   typedef enum logic [2:0] {S_IDLE, S_FETCH0, S_FETCH1, S_WAIT, S_MEM, S_PAUSE} adma_state_t;
   localparam logic [1:0] RA_CMD  = 2'd0;
   localparam logic [1:0] RA_STAT = 2'd1;
   localparam logic [1:0] RA_TAB  = 2'd2;
   localparam int CMD_RUN = 0;
   localparam int CMD_DIR = 3;
   localparam int ST_PAGE = 0;
   localparam int ST_FAULT = 1;
   localparam int ST_END  = 2;
   localparam int FL_EOT = 31;
   localparam int FL_EOP = 30;
   localparam int FL_JMP = 29;
   localparam int DESC_BYTES = 8;
endpackage

// File: rtl/adma_regs.sv
module adma_regs
   import adma_pkg::*;
#(
   parameter int AW = 32,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          busy,
   input  logic [AW-1:0] tab,
   input  logic          ev_page,
   input  logic          ev_fault,
   input  logic          ev_end,
   output logic          go,
   output logic          stop,
   output logic          dir,
   output logic          tab_we,
   output logic          page_pend,
   output logic          irq
);
   logic [2:0] stat_q;
   logic       dir_q;
   logic       wr_cmd, rd_stat, ev_any;
   logic       unused_wd;

   assign unused_wd = ^reg_wdata;
   assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);
   assign rd_stat = reg_rd && (reg_addr == RA_STAT);
   assign go      = wr_cmd && reg_wdata[CMD_RUN] && !busy;
   assign stop    = wr_cmd && !reg_wdata[CMD_RUN];
   assign tab_we  = reg_wr && (reg_addr == RA_TAB) && !busy;
   assign ev_any  = ev_page || ev_fault || ev_end;
   assign dir       = dir_q;
   assign page_pend = stat_q[ST_PAGE];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         dir_q  <= 1'b0;
      end else begin
         if (rd_stat) stat_q <= '0;
         if (ev_page)  stat_q[ST_PAGE]  <= 1'b1;
         if (ev_fault) stat_q[ST_FAULT] <= 1'b1;
         if (ev_end)   stat_q[ST_END]   <= 1'b1;
         if (wr_cmd && !busy) dir_q <= reg_wdata[CMD_DIR];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CMD: begin
            reg_rdata[CMD_RUN] = busy;
            reg_rdata[CMD_DIR] = dir_q;
         end
         RA_STAT: reg_rdata[2:0] = stat_q;
         RA_TAB:  reg_rdata[AW-1:0] = tab;
         default: reg_rdata = '0;
      endcase
   end

   generate
      if (IRQ_PULSE) begin : g_irq_pulse
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= ev_any;
         end
         assign irq = irq_q;
      end else begin : g_irq_level
         assign irq = |stat_q;
      end
   endgenerate

   assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !ev_any) |=> (stat_q == '0));
   assert_page_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_page |-> !stat_q[ST_PAGE]);
   assert_fault_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_fault |=> stat_q[ST_FAULT]);
endmodule

// File: rtl/adma_ctrl.sv
module adma_ctrl
   import adma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          stop,
   input  logic          dir,
   input  logic          tab_we,
   input  logic [AW-1:0] tab_wdata,
   input  logic          page_pend,
   output logic [AW-1:0] tab,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_err,
   input  logic [31:0]   mem_rdata,
   input  logic          link_req,
   input  logic [31:0]   link_din,
   output logic          link_ack,
   output logic [31:0]   link_dout,
   output logic          busy,
   output logic          ev_page,
   output logic          ev_fault,
   output logic          ev_end
);
   localparam int WW = CW - 2;

   adma_state_t   st;
   logic [AW-1:0] tab_q, buf_q;
   logic [WW-1:0] wcnt_q;
   logic          fl_eot, fl_eop;
   logic [31:0]   din_q, dout_q;
   logic          ack_q;
   logic          fault, fin, overrun;
   logic          unused_rd;

   assign unused_rd = ^{mem_rdata[FL_JMP-1:CW], mem_rdata[1:0]};

   assign mem_req   = (st == S_FETCH0) || (st == S_FETCH1) || (st == S_MEM);
   assign mem_we    = (st == S_MEM) && dir;
   assign mem_addr  = (st == S_FETCH0) ? tab_q :
                      (st == S_FETCH1) ? tab_q + AW'(4) : buf_q;
   assign mem_wdata = din_q;
   assign fault     = mem_req && mem_ack && mem_err;
   assign fin       = (st == S_WAIT) && (wcnt_q == '0);
   assign overrun   = fin && fl_eop && page_pend;
   assign ev_fault  = fault || overrun;
   assign ev_page   = fin && fl_eop && !page_pend;
   assign ev_end    = fin && fl_eot && !overrun;
   assign busy      = (st != S_IDLE);
   assign tab       = tab_q;
   assign link_ack  = ack_q;
   assign link_dout = dout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         tab_q  <= '0;
         buf_q  <= '0;
         wcnt_q <= '0;
         fl_eot <= 1'b0;
         fl_eop <= 1'b0;
         din_q  <= '0;
         dout_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         case (st)
            S_IDLE: begin
               if (tab_we) tab_q <= tab_wdata;
               if (go) st <= S_FETCH0;
            end
            S_FETCH0: if (mem_ack) begin
               if (mem_err) st <= S_PAUSE;
               else begin
                  buf_q <= mem_rdata[AW-1:0];
                  st    <= S_FETCH1;
               end
            end
            S_FETCH1: if (mem_ack) begin
               if (mem_err) st <= S_PAUSE;
               else begin
                  fl_eot <= mem_rdata[FL_EOT];
                  fl_eop <= mem_rdata[FL_EOP];
                  wcnt_q <= mem_rdata[CW-1:2];
                  if (mem_rdata[FL_JMP]) begin
                     tab_q <= buf_q;
                     st    <= S_FETCH0;
                  end else begin
                     tab_q <= tab_q + AW'(DESC_BYTES);
                     st    <= S_WAIT;
                  end
               end
            end
            S_WAIT: begin
               if (fin) begin
                  if (overrun)     st <= S_PAUSE;
                  else if (fl_eot) st <= S_IDLE;
                  else             st <= S_FETCH0;
               end else if (link_req) begin
                  din_q <= link_din;
                  st    <= S_MEM;
               end
            end
            S_MEM: if (mem_ack) begin
               if (mem_err) st <= S_PAUSE;
               else begin
                  ack_q  <= 1'b1;
                  if (!dir) dout_q <= mem_rdata;
                  buf_q  <= buf_q + AW'(4);
                  wcnt_q <= wcnt_q - WW'(1);
                  st     <= S_WAIT;
               end
            end
            S_PAUSE: if (stop) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assert_table_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FETCH1 && mem_ack && !mem_err && !mem_rdata[FL_JMP])
      |=> (tab_q == $past(tab_q) + AW'(DESC_BYTES)));
   assert_jump_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_FETCH1 && mem_ack && !mem_err && mem_rdata[FL_JMP])
      |=> (tab_q == $past(buf_q) && st == S_FETCH0));
   assert_fault_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fault |=> (st == S_PAUSE));
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      link_ack |=> !link_ack);
   assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && (st == S_WAIT) && !fin) |=> busy);
endmodule

// File: rtl/adma_engine.sv
module adma_engine
   import adma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [1:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [31:0]   mem_wdata,
   input  logic          mem_ack,
   input  logic          mem_err,
   input  logic [31:0]   mem_rdata,
   input  logic          link_req,
   input  logic [31:0]   link_din,
   output logic          link_ack,
   output logic [31:0]   link_dout,
   output logic          irq
);
   generate
      if (AW < 8 || AW > 32) begin : g_bad_aw
         $error("adma_engine: AW must lie in 8..32");
      end
      if (CW < 3 || CW > 16) begin : g_bad_cw
         $error("adma_engine: CW must lie in 3..16");
      end
   endgenerate

   logic          go, stop, dir, tab_we, page_pend, busy;
   logic          ev_page, ev_fault, ev_end;
   logic [AW-1:0] tab;

   adma_regs #(.AW(AW), .IRQ_PULSE(IRQ_PULSE)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .busy(busy), .tab(tab), .ev_page(ev_page), .ev_fault(ev_fault),
      .ev_end(ev_end), .go(go), .stop(stop), .dir(dir), .tab_we(tab_we),
      .page_pend(page_pend), .irq(irq)
   );

   adma_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .go(go), .stop(stop), .dir(dir),
      .tab_we(tab_we), .tab_wdata(reg_wdata[AW-1:0]), .page_pend(page_pend),
      .tab(tab), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata), .link_req(link_req), .link_din(link_din),
      .link_ack(link_ack), .link_dout(link_dout), .busy(busy),
      .ev_page(ev_page), .ev_fault(ev_fault), .ev_end(ev_end)
   );
endmodule

// File: tb/adma_engine_bench.sv
module adma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0, mem_err = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        link_req = 1'b0;
   logic [31:0] link_din;
   logic        link_ack;
   logic [31:0] link_dout;
   logic        irq;

   logic [31:0] mem [0:63];
   logic [31:0] exp_q [$];
   logic [31:0] cap_w [0:3];
   int          cap_i = 0;
   logic        cap_mode = 1'b0;
   logic        fault_en = 1'b0;
   logic [31:0] fault_addr = '0;
   int          n_chk = 0, n_err = 0;
   logic [31:0] rv;

   always #10 clk = ~clk;

   adma_engine u_adma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
      .mem_rdata(mem_rdata), .link_req(link_req), .link_din(link_din),
      .link_ack(link_ack), .link_dout(link_dout), .irq(irq)
   );

   assign link_din = cap_w[cap_i[1:0]];

   always @(posedge clk) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
      if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (fault_en && mem_addr == fault_addr) mem_err <= 1'b1;
         else if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
         else mem_rdata <= mem[mem_addr[7:2]];
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && link_ack) begin
         if (cap_mode) cap_i++;
         else if (exp_q.size() == 0) check("R3 unexpected word to codec", link_dout, 32'hxxxxxxxx);
         else check("R3 playback word order", link_dout, exp_q.pop_front());
      end
   end

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 + i;
      // playback ring: page then end
      mem[0] = 32'h40; mem[1] = (32'h1 << 30) | 32'd8;
      mem[2] = 32'h60; mem[3] = (32'h1 << 31) | 32'd4;
      // single descriptor hitting a faulting buffer
      mem[8] = 32'h60; mem[9] = (32'h1 << 31) | 32'd4;
      // jump entry then capture descriptor
      mem[32] = 32'h90; mem[33] = 32'h1 << 29;
      mem[36] = 32'hA0; mem[37] = (32'h1 << 31) | 32'd8;
      // two pages without acknowledge
      mem[48] = 32'h40; mem[49] = (32'h1 << 30) | 32'd4;
      mem[50] = 32'h40; mem[51] = (32'h1 << 30) | 32'd4;
      mem[52] = 32'h40; mem[53] = (32'h1 << 31) | 32'd4;
      cap_w[0] = 32'h1111_2222; cap_w[1] = 32'h3333_4444;
      cap_w[2] = 32'h0; cap_w[3] = 32'h0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("reset irq", {31'b0, irq}, 32'h0);
      rd_reg(2'd1, rv); check("R6 reset status", rv, 32'h0);
      rd_reg(2'd0, rv); check("R1 reset command", rv, 32'h0);
      rd_reg(2'd2, rv); check("R2 reset table address", rv, 32'h0);

      // playback, with a disable attempt while running
      exp_q.push_back(32'hA500_0010);
      exp_q.push_back(32'hA500_0011);
      exp_q.push_back(32'hA500_0018);
      wr_reg(2'd2, 32'h0);
      wr_reg(2'd0, 32'h1);
      repeat (20) @(negedge clk);
      rd_reg(2'd0, rv); check("R1 active after start", rv, 32'h1);
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd0, rv); check("R9 disable ignored while running", rv, 32'h1);
      link_req = 1'b1;
      repeat (100) @(negedge clk);
      check("R3 all playback words served", exp_q.size(), 32'd0);
      check("R4 R8 irq raised", {31'b0, irq}, 32'h1);
      rd_reg(2'd1, rv); check("R4 R8 page and end status", rv, 32'h5);
      rd_reg(2'd1, rv); check("R6 status cleared by read", rv, 32'h0);
      check("R6 irq falls after clear", {31'b0, irq}, 32'h0);
      rd_reg(2'd2, rv); check("R2 table advanced by 8 per entry", rv, 32'h10);
      rd_reg(2'd0, rv); check("R8 idle after end of table", rv, 32'h0);

      // capture through a jump entry
      cap_mode = 1'b1;
      wr_reg(2'd2, 32'h80);
      wr_reg(2'd0, 32'h9);
      repeat (100) @(negedge clk);
      check("R3 capture word 0", mem[40], 32'h1111_2222);
      check("R3 capture word 1", mem[41], 32'h3333_4444);
      check("R7 jump entry moved no data", mem[42], 32'hA500_002A);
      rd_reg(2'd2, rv); check("R7 table follows jump target", rv, 32'h98);
      rd_reg(2'd1, rv); check("R8 end status after capture", rv, 32'h4);
      wr_reg(2'd0, 32'h0);
      cap_mode = 1'b0;

      // second page without acknowledge
      exp_q.push_back(32'hA500_0010);
      exp_q.push_back(32'hA500_0010);
      wr_reg(2'd2, 32'hC0);
      wr_reg(2'd0, 32'h1);
      repeat (150) @(negedge clk);
      check("R4 continued to second page", exp_q.size(), 32'd0);
      rd_reg(2'd1, rv); check("R5 overrun gives page and error", rv, 32'h3);
      rd_reg(2'd0, rv); check("R5 engine paused not idle", rv, 32'h1);
      rd_reg(2'd2, rv); check("R5 no third fetch", rv, 32'hD0);
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd0, rv); check("R9 disable while paused", rv, 32'h0);

      // memory error response on a data access
      fault_en = 1'b1; fault_addr = 32'h60;
      wr_reg(2'd2, 32'h20);
      wr_reg(2'd0, 32'h1);
      repeat (60) @(negedge clk);
      check("R10 irq on error", {31'b0, irq}, 32'h1);
      rd_reg(2'd1, rv); check("R10 error status", rv, 32'h2);
      rd_reg(2'd0, rv); check("R10 paused after error", rv, 32'h1);
      wr_reg(2'd0, 32'h0);
      rd_reg(2'd0, rv); check("R9 idle after disable", rv, 32'h0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule